// File: doc/BRIEF.md
# Multi-Card SPI Host Controller

This block is a polled peripheral on an 8-bit register path of a 16-bit host address bus. It drives one SPI link shared by up to four memory cards, each of which has its own active-low chip select. Software can run the link in two ways:

- **Bit-bang mode.** A control register drives the serial clock and data-out pins directly, and a status register shows the data-in pin. This slow mode is used, for example, to bring older multimedia cards out of their power-up state.
- **Shift mode.** A byte written to the data register is sent by a hardware shifter, eight bits MSB first in SPI mode 0. The byte captured from the card is then read back from the same register.

The block raises no interrupts. Software polls a busy flag.

Four byte registers sit at offsets 0 to 3 inside a 256-byte page. The page is chosen by `baseSel`.

| Offset | Register | Access | Contents |
|---|---|---|---|
| 0 | CTRL | read/write | bit0 mode (1 = shift), bit1 bit-bang clock, bit2 bit-bang data out |
| 1 | CSEL | read/write | bit7 enable, bits[1:0] card index |
| 2 | DATA | read/write | write starts a transfer; read returns the last received byte |
| 3 | STATUS | read only | bit0 busy, bit1 live data-in level, bit2 mode |

Top module: `spiHostCtrl`

## Requirements
- R1: After reset all chip selects are high, the serial clock and data-out pins are low, the busy flag is 0, and bit-bang mode is selected (CTRL reads 0).
- R2: An access is decoded only when `busAddr[15:8]` equals `baseSel` and `busAddr[7:2]` is zero. Any other write changes no register. Any other read, and any cycle with `busRd` low, returns 0.
- R3: In bit-bang mode the clock and data-out pins follow CTRL bit1 and bit2 from the cycle after the write. STATUS bit1 reads the data-in pin level.
- R4: Writing CSEL with bit7 set drives low only the chip select numbered by bits[1:0]. Writing it with bit7 clear drives all chip selects high. No more than one chip select is ever low, and the chip selects behave the same in both modes.
- R5: In shift mode a DATA write sends the written byte MSB first. Data-out changes only while the clock is low, so a card samples each bit on a rising clock edge.
- R6: The shifter samples data-in on each rising clock edge, MSB first. When the transfer ends, a DATA read returns the eight sampled bits.
- R7: Busy rises on the clock edge that takes the DATA write and falls 16*DIV_HALF cycles later. During that time there are exactly eight clock pulses with a period of 2*DIV_HALF cycles. In shift mode the clock idles low.
- R8: A DATA write while busy is high is ignored, and so is a DATA write in bit-bang mode. Neither write produces any clock pulse.
- R9: A DATA write that falls on the very edge where busy clears is ignored. A write one cycle later starts a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| baseSel | input | 8 | Page number compared with the upper address byte |
| busAddr | input | 16 | Host address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, zero when not selected |
| spiSclk | output | 1 | Serial clock to the cards |
| spiMosi | output | 1 | Serial data to the cards |
| spiMiso | input | 1 | Serial data from the cards |
| spiCsN | output | 4 | Active-low card selects |

## Verification
Two functions can meet on a single clock edge: the shifter finishing a transfer, and a new DATA write that would start the next one. The bench writes a byte and then counts exactly 16*DIV_HALF - 1 further edges. It places a second write on the edge where busy clears.

That second write must leave no trace:
- busy reads 0 afterwards;
- the count of rising clock pulses stays at eight;
- the byte captured by the modelled card is still the first one.

A write one cycle later must start a fresh transfer.

// File: rtl/spiHostPkg.sv
package spiHostPkg;

  localparam int REG_OFF_W = 2;

  typedef enum logic [REG_OFF_W-1:0] {
    OFF_CTRL   = 2'd0,
    OFF_CSEL   = 2'd1,
    OFF_DATA   = 2'd2,
    OFF_STATUS = 2'd3
  } regOff_e;

  // Strobes and levels handed from the register control to the datapath.
  typedef struct packed {
    logic       start;
    logic       shiftMode;
    logic       bbSclk;
    logic       bbMosi;
    logic [7:0] txByte;
  } dpCmd_t;

endpackage

// File: rtl/spiHostCtl.sv
module spiHostCtl
  import spiHostPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_CARDS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-9:0] baseSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWrData,
  input  logic              dpBusy,
  input  logic [7:0]        rxByte,
  input  logic              misoLvl,
  output logic [7:0]        busRdData,
  output dpCmd_t            cmd,
  output logic [NUM_CARDS-1:0] csN
);

  localparam int IDX_W  = (NUM_CARDS > 1) ? $clog2(NUM_CARDS) : 1;
  localparam int PAGE_W = ADDR_W - 8;

  logic             hit;
  regOff_e          off;
  logic             wrHit;
  logic             modeQ;
  logic             bbSclkQ;
  logic             bbMosiQ;
  logic             csEnQ;
  logic [IDX_W-1:0] csIdxQ;

  // Full decode: the page must match and the offset must lie in 0..3.
  assign hit   = (busAddr[ADDR_W-1 -: PAGE_W] == baseSel) &&
                 (busAddr[7:REG_OFF_W] == '0);
  assign off   = regOff_e'(busAddr[REG_OFF_W-1:0]);
  assign wrHit = busWr && hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= 1'b0;
      bbSclkQ <= 1'b0;
      bbMosiQ <= 1'b0;
      csEnQ   <= 1'b0;
      csIdxQ  <= '0;
    end else if (wrHit) begin
      case (off)
        OFF_CTRL: begin
          modeQ   <= busWrData[0];
          bbSclkQ <= busWrData[1];
          bbMosiQ <= busWrData[2];
        end
        OFF_CSEL: begin
          csEnQ  <= busWrData[7];
          csIdxQ <= busWrData[IDX_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // A transfer starts only in shift mode and only when the shifter is idle.
  always_comb begin
    cmd.start     = wrHit && (off == OFF_DATA) && modeQ && !dpBusy;
    cmd.shiftMode = modeQ;
    cmd.bbSclk    = bbSclkQ;
    cmd.bbMosi    = bbMosiQ;
    cmd.txByte    = busWrData;
  end

  // One-hot chip-select decode, one low line at most.
  for (genvar g = 0; g < NUM_CARDS; g++) begin : gCs
    assign csN[g] = !(csEnQ && (csIdxQ == IDX_W'(g)));
  end

  always_comb begin
    busRdData = '0;
    if (busRd && hit) begin
      case (off)
        OFF_CTRL: busRdData = {5'b0, bbMosiQ, bbSclkQ, modeQ};
        OFF_CSEL: begin
          busRdData[7]         = csEnQ;
          busRdData[IDX_W-1:0] = csIdxQ;
        end
        OFF_DATA:   busRdData = rxByte;
        OFF_STATUS: busRdData = {5'b0, modeQ, misoLvl, dpBusy};
        default:    busRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/spiHostDp.sv
module spiHostDp
  import spiHostPkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic       miso,
  output logic       busy,
  output logic [7:0] rxByte,
  output logic       sclk,
  output logic       mosi
);

  localparam int CNT_W = $clog2(DIV_HALF) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic             busyQ;
  logic             sclkQ;
  logic [7:0]       txQ;
  logic [7:0]       rxShQ;
  logic [7:0]       rxHoldQ;
  logic [2:0]       bitQ;
  logic [CNT_W-1:0] cntQ;
  logic             phaseEnd;

  assign phaseEnd = (cntQ == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      sclkQ   <= 1'b0;
      txQ     <= '0;
      rxShQ   <= '0;
      rxHoldQ <= '0;
      bitQ    <= '0;
      cntQ    <= '0;
    end else if (cmd.start && !busyQ) begin
      busyQ <= 1'b1;
      sclkQ <= 1'b0;
      txQ   <= cmd.txByte;
      bitQ  <= '0;
      cntQ  <= '0;
    end else if (busyQ) begin
      if (!phaseEnd) begin
        cntQ <= cntQ + 1'b1;
      end else begin
        cntQ <= '0;
        if (!sclkQ) begin
          // Rising edge: capture the card's bit.
          sclkQ <= 1'b1;
          rxShQ <= {rxShQ[6:0], miso};
        end else begin
          // Falling edge: advance the outgoing bit or finish.
          sclkQ <= 1'b0;
          if (bitQ == 3'd7) begin
            busyQ   <= 1'b0;
            rxHoldQ <= rxShQ;
          end else begin
            bitQ <= bitQ + 1'b1;
            txQ  <= {txQ[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign busy   = busyQ;
  assign rxByte = rxHoldQ;
  assign sclk   = cmd.shiftMode ? sclkQ : cmd.bbSclk;
  assign mosi   = cmd.shiftMode ? (busyQ & txQ[7]) : cmd.bbMosi;

endmodule

// File: rtl/spiHostCtrl.sv
module spiHostCtrl
  import spiHostPkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int NUM_CARDS = 4,
  parameter int DIV_HALF  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-9:0]    baseSel,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [7:0]           busWrData,
  output logic [7:0]           busRdData,
  output logic                 spiSclk,
  output logic                 spiMosi,
  input  logic                 spiMiso,
  output logic [NUM_CARDS-1:0] spiCsN
);

  dpCmd_t     dpCmd;
  logic       dpBusy;
  logic [7:0] dpRx;

  spiHostCtl #(
    .ADDR_W   (ADDR_W),
    .NUM_CARDS(NUM_CARDS)
  ) ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .baseSel  (baseSel),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWrData(busWrData),
    .dpBusy   (dpBusy),
    .rxByte   (dpRx),
    .misoLvl  (spiMiso),
    .busRdData(busRdData),
    .cmd      (dpCmd),
    .csN      (spiCsN)
  );

  spiHostDp #(
    .DIV_HALF(DIV_HALF)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .cmd   (dpCmd),
    .miso  (spiMiso),
    .busy  (dpBusy),
    .rxByte(dpRx),
    .sclk  (spiSclk),
    .mosi  (spiMosi)
  );

endmodule

// File: rtl/spiHostChk.sv
module spiHostChk #(
  parameter int ADDR_W    = 16,
  parameter int NUM_CARDS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-9:0]    baseSel,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWr,
  input logic                 busRd,
  input logic [7:0]           busRdData,
  input logic                 spiSclk,
  input logic                 spiMosi,
  input logic [NUM_CARDS-1:0] spiCsN,
  input logic                 busy,
  input logic                 shiftMode
);

  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (spiCsN == '1) && !spiSclk && !spiMosi && !busy);

  a_r2_unselected_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!busRd || (busAddr[ADDR_W-1:8] != baseSel)) |-> (busRdData == 8'h00));

  a_r4_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~spiCsN) <= 1);

  a_r5_mosi_steady_high_clk: assert property (@(posedge clk) disable iff (!rstN)
    (shiftMode && spiSclk && $past(spiSclk) && $past(shiftMode)) |-> $stable(spiMosi));

  a_r7_idle_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    (shiftMode && !busy) |-> !spiSclk);

  a_r8_busy_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busWr));

endmodule

bind spiHostCtrl spiHostChk #(
  .ADDR_W   (ADDR_W),
  .NUM_CARDS(NUM_CARDS)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .baseSel  (baseSel),
  .busAddr  (busAddr),
  .busWr    (busWr),
  .busRd    (busRd),
  .busRdData(busRdData),
  .spiSclk  (spiSclk),
  .spiMosi  (spiMosi),
  .spiCsN   (spiCsN),
  .busy     (dpBusy),
  .shiftMode(dpCmd.shiftMode)
);

// File: tb/spiHostCtrl_tb.sv
module spiHostCtrl_tb_top;

  localparam int H        = 2;
  localparam int XFER     = 16 * H;
  localparam logic [7:0] BASE = 8'h5A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  baseSel = BASE;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        spiSclk;
  logic        spiMosi;
  logic        spiMiso;
  logic [3:0]  spiCsN;

  int checks = 0;
  int errors = 0;

  // Card model: shifts MOSI in on rise, presents MSB-first on MISO.
  logic [7:0] slvTx = '0;
  logic [7:0] slvRx = '0;
  logic [2:0] slvIdx = '0;
  int         riseCnt = 0;
  time        lastRise = 0;
  time        period = 0;
  logic       bbMisoForce = 1'b0;
  logic       useForce = 1'b0;

  assign spiMiso = useForce ? bbMisoForce : slvTx[3'd7 - slvIdx];

  always #2 clk = ~clk;

  always @(posedge spiSclk) begin
    slvRx   <= {slvRx[6:0], spiMosi};
    riseCnt <= riseCnt + 1;
    if (lastRise != 0) period <= $time - lastRise;
    lastRise <= $time;
  end
  always @(negedge spiSclk) slvIdx <= slvIdx + 3'd1;

  spiHostCtrl dut_i (
    .clk(clk), .rstN(rstN), .baseSel(baseSel), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWrData(busWrData),
    .busRdData(busRdData), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrRaw(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic wr(input logic [1:0] off, input logic [7:0] d);
    wrRaw({BASE, 6'b0, off}, d);
  endtask

  task automatic rdRaw(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    busRd = 1'b0;
  endtask

  task automatic rd(input logic [1:0] off, output logic [7:0] d);
    rdRaw({BASE, 6'b0, off}, d);
  endtask

  task automatic clearModel(input logic [7:0] stx);
    @(negedge clk);
    slvTx = stx; slvIdx = '0; riseCnt = 0; lastRise = 0; period = 0;
  endtask

  task automatic waitIdle(output int n);
    logic [7:0] s;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      rd(2'd3, s);
      if (!s[0]) break;
      n++;
    end
  endtask

  task automatic tReset();
    logic [7:0] d;
    check("R1 csN", spiCsN, 4'hF);
    check("R1 sclk", spiSclk, 0);
    check("R1 mosi", spiMosi, 0);
    rd(2'd0, d); check("R1 ctrl", d, 0);
    rd(2'd3, d); check("R1 busy", d[0], 0);
  endtask

  task automatic tDecode();
    logic [7:0] d;
    wr(2'd1, 8'h81);
    wrRaw({8'h5B, 8'h01}, 8'h83);
    rd(2'd1, d); check("R2 page mismatch write", d, 8'h81);
    wrRaw({BASE, 8'h05}, 8'h80);
    rd(2'd1, d); check("R2 offset out of range write", d, 8'h81);
    check("R2 cs unchanged", spiCsN, 4'b1101);
    rdRaw({8'h5B, 8'h01}, d); check("R2 page mismatch read", d, 0);
    rdRaw({BASE, 8'h41}, d); check("R2 offset mismatch read", d, 0);
    wr(2'd1, 8'h00);
  endtask

  task automatic tBitBang();
    logic [7:0] s;
    wr(2'd0, 8'h02);
    check("R3 sclk follows", spiSclk, 1);
    check("R3 mosi follows", spiMosi, 0);
    wr(2'd0, 8'h04);
    check("R3 sclk low", spiSclk, 0);
    check("R3 mosi high", spiMosi, 1);
    useForce = 1'b1; bbMisoForce = 1'b1;
    rd(2'd3, s); check("R3 miso level 1", s[1], 1);
    bbMisoForce = 1'b0;
    rd(2'd3, s); check("R3 miso level 0", s[1], 0);
    useForce = 1'b0;
    wr(2'd0, 8'h00);
  endtask

  task automatic tChipSel();
    for (int i = 0; i < 4; i++) begin
      wr(2'd1, 8'h80 | 8'(i));
      check("R4 one cs low", spiCsN, 4'hF & ~(4'b1 << i));
    end
    wr(2'd0, 8'h01);
    check("R4 cs kept in shift mode", spiCsN, 4'b0111);
    wr(2'd1, 8'h02);
    check("R4 disable all", spiCsN, 4'hF);
    wr(2'd0, 8'h00);
  endtask

  task automatic tShift(input logic [7:0] tx, input logic [7:0] stx);
    logic [7:0] d;
    int n;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h80);
    clearModel(stx);
    wr(2'd2, tx);
    waitIdle(n);
    check("R7 busy cycles", n, XFER - 1);
    check("R7 eight pulses", riseCnt, 8);
    check("R7 clock period", int'(period), 2 * H * 4);
    check("R5 card got byte", slvRx, tx);
    rd(2'd2, d); check("R6 received byte", d, stx);
    check("R7 idle clock low", spiSclk, 0);
  endtask

  task automatic tIgnore();
    logic [7:0] d;
    int n;
    wr(2'd0, 8'h00);
    clearModel(8'h00);
    wr(2'd2, 8'hF0);
    rd(2'd3, d); check("R8 no start in bit-bang", d[0], 0);
    check("R8 no pulses in bit-bang", riseCnt, 0);
    wr(2'd0, 8'h01);
    clearModel(8'h3C);
    wr(2'd2, 8'hA5);
    repeat (5) @(negedge clk);
    wr(2'd2, 8'h11);
    waitIdle(n);
    check("R8 pulses while busy", riseCnt, 8);
    check("R8 first byte kept", slvRx, 8'hA5);
    rd(2'd2, d); check("R8 rx from first", d, 8'h3C);
  endtask

  task automatic tCollide();
    logic [7:0] d;
    int n;
    wr(2'd0, 8'h01);
    clearModel(8'h5A);
    wr(2'd2, 8'hC3);
    repeat (XFER - 1) @(posedge clk);
    wr(2'd2, 8'h3C);
    rd(2'd3, d); check("R9 write on done edge ignored", d[0], 0);
    repeat (XFER) @(negedge clk);
    check("R9 no extra pulses", riseCnt, 8);
    check("R9 first byte kept", slvRx, 8'hC3);
    clearModel(8'h0F);
    wr(2'd2, 8'h96);
    rd(2'd3, d); check("R9 next write accepted", d[0], 1);
    waitIdle(n);
    check("R9 second byte sent", slvRx, 8'h96);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tReset();
    tDecode();
    tBitBang();
    tChipSel();
    tShift(8'hA5, 8'h5A);
    tShift(8'h00, 8'hFF);
    tShift(8'h81, 8'h7E);
    tIgnore();
    tCollide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule